// File: doc/BRIEF.md
# DMA Channel Interrupt Cause Unit

This block gathers the event and error sources of one DMA channel into a set of sticky cause bits. Each cause is masked by a matching enable bit, and the result drives the channel's single interrupt. A source is captured on its rising edge and stays latched until software writes a one to that bit in the clear register. Masking a source stops it from reaching the interrupt, but the source still latches.

A small register port gives software access to the status, enable, clear and mode registers. Only six bit positions carry sources: 0 (end-of-block), 1 (event-write response error), 9 (descriptor read-response error), 10 (data read error), 11 (data write error) and 14 (invalid descriptor). Every other position is tied to zero.

A 4-bit mode field chooses how the interrupt is delivered. In wired mode the block drives a level output. In message mode it instead emits a single-cycle pulse that carries the masked cause vector.

Top module: `irq_cause_unit`

## Requirements
- R1: A status bit is set in the cycle after the clock edge at which its source input is sampled high, having been sampled low at the previous edge (or, for the first edge after reset, at reset). A source held high does not set the bit again after it has been cleared.
- R2: A status bit (read at offset 0x100) holds its value until a write to offset 0x108 carries a 1 in that same bit. Zero bits in that write leave the status bit unchanged.
- R3: When a rising source and a clear of the same bit fall in the same cycle, the bit ends up set.
- R4: Only bits 0, 1, 9, 10, 11 and 14 (mask 0x4E03) exist. Every other bit reads as zero in status and enable, and writes and source edges on those bits have no effect.
- R5: The enable register at offset 0x110 is written and read back at that offset. The effective cause is status AND enable.
- R6: Bits 3:0 at offset 0x004 select the mode, and the value 1 selects wired mode. In wired mode, irq_o is high exactly when the effective cause is nonzero. In any other mode, irq_o is low.
- R7: In message mode (mode field not equal to 1), msg_valid_o pulses high for one cycle when the effective cause goes from zero to nonzero. During the pulse, msg_cause_o carries the effective cause. At all other times msg_cause_o is zero.
- R8: When enable is zero, irq_o stays low but status bits still latch. A later enable write raises irq_o for the bits that were already latched.
- R9: After reset, status and enable are zero, the mode field is 1, and irq_o and msg_valid_o are low.
- R10: A read of the clear register, or of any offset other than 0x004, 0x100 and 0x110, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | DATA_W | Raw source levels, one per bit position |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt, active only in wired mode |
| msg_valid_o | output | 1 | One-cycle message strobe in message mode |
| msg_cause_o | output | DATA_W | Effective cause vector during the strobe, zero otherwise |

## Verification
A status bit that is lost, stuck or set twice shows at offset 0x100 one cycle after the source edge or clear write that caused it. In wired mode the same fault appears on irq_o in that same cycle. A stale copy of the previous cause in the message path shows up either as a missing pulse or as a second pulse. The bench can see this in the cycle after the cause becomes nonzero, or when a second source rises while the cause is already nonzero. A wrong enable or mode value is visible immediately on read-back and on irq_o.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned MODE_W = 4;

  localparam logic [REG_AW-1:0] OFF_MODE = 12'h004;
  localparam logic [REG_AW-1:0] OFF_STAT = 12'h100;
  localparam logic [REG_AW-1:0] OFF_CLR  = 12'h108;
  localparam logic [REG_AW-1:0] OFF_ENA  = 12'h110;

  localparam int unsigned BIT_EOB      = 0;
  localparam int unsigned BIT_EVWR_ERR = 1;
  localparam int unsigned BIT_DSC_ERR  = 9;
  localparam int unsigned BIT_RD_ERR   = 10;
  localparam int unsigned BIT_WR_ERR   = 11;
  localparam int unsigned BIT_BAD_DSC  = 14;

  localparam logic [31:0] DEF_SRC_MASK =
      (32'd1 << BIT_EOB) | (32'd1 << BIT_EVWR_ERR) | (32'd1 << BIT_DSC_ERR) |
      (32'd1 << BIT_RD_ERR) | (32'd1 << BIT_WR_ERR) | (32'd1 << BIT_BAD_DSC);

  localparam logic [MODE_W-1:0] MODE_WIRED = 4'd1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_STAT,
    SEL_CLR,
    SEL_ENA
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cause_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output reg_sel_e          sel_o,
  output logic              mode_we_o,
  output logic              ena_we_o,
  output logic [DATA_W-1:0] clr_vec_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFF_MODE))      sel_o = SEL_MODE;
    else if (addr_i == ADDR_W'(OFF_STAT)) sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFF_CLR))  sel_o = SEL_CLR;
    else if (addr_i == ADDR_W'(OFF_ENA))  sel_o = SEL_ENA;
    else                                  sel_o = SEL_NONE;
  end

  assign mode_we_o = we_i && (sel_o == SEL_MODE);
  assign ena_we_o  = we_i && (sel_o == SEL_ENA);
  assign clr_vec_o = (we_i && (sel_o == SEL_CLR)) ? wdata_i : '0;
endmodule

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] SRC_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] rise_o
);
  logic [DATA_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  // undefined positions never produce an edge
  assign rise_o = src_i & ~src_q & SRC_MASK;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] SRC_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rise_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              ena_we_i,
  input  logic [DATA_W-1:0] ena_wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic [DATA_W-1:0] cause_o
);
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] enable_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else         status_q[i] <= SRC_MASK[i] & (rise_i[i] | (status_q[i] & ~clr_i[i]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       enable_q[i] <= 1'b0;
      else if (ena_we_i) enable_q[i] <= SRC_MASK[i] & ena_wdata_i[i];
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign cause_o  = status_q & enable_q;
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
  import irq_cause_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic [DATA_W-1:0] cause_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o,
  output logic              msg_valid_o,
  output logic [DATA_W-1:0] msg_cause_o
);
  logic [MODE_W-1:0] mode_q;
  logic              any_q;
  logic              any_now;
  logic              wired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_WIRED;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  // tracks the cause in both modes, so a mode switch never emits a stale message
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= any_now;
  end

  assign any_now     = |cause_i;
  assign wired       = (mode_q == MODE_WIRED);
  assign irq_o       = wired & any_now;
  assign msg_valid_o = ~wired & any_now & ~any_q;
  assign msg_cause_o = msg_valid_o ? cause_i : '0;
  assign mode_o      = mode_q;
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = REG_AW,
  parameter logic [DATA_W-1:0] SRC_MASK = DATA_W'(DEF_SRC_MASK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              msg_valid_o,
  output logic [DATA_W-1:0] msg_cause_o
);
  reg_sel_e          sel;
  logic              mode_we;
  logic              ena_we;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] cause;
  logic [MODE_W-1:0] mode_q;

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .sel_o     (sel),
    .mode_we_o (mode_we),
    .ena_we_o  (ena_we),
    .clr_vec_o (clr_vec)
  );

  irq_rise_detect #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irq_status_bank #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .clr_i       (clr_vec),
    .ena_we_i    (ena_we),
    .ena_wdata_i (reg_wdata_i),
    .status_o    (status_q),
    .enable_o    (enable_q),
    .cause_o     (cause)
  );

  irq_deliver #(.DATA_W(DATA_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_we_i    (mode_we),
    .mode_wdata_i (reg_wdata_i[MODE_W-1:0]),
    .cause_i      (cause),
    .mode_o       (mode_q),
    .irq_o        (irq_o),
    .msg_valid_o  (msg_valid_o),
    .msg_cause_o  (msg_cause_o)
  );

  always_comb begin
    unique case (sel)
      SEL_MODE: reg_rdata_o = DATA_W'(mode_q);
      SEL_STAT: reg_rdata_o = status_q;
      SEL_ENA:  reg_rdata_o = enable_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MODE_W = 4,
  parameter logic [DATA_W-1:0] SRC_MASK = '1,
  parameter logic [ADDR_W-1:0] CLR_OFF = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] src_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic              msg_valid_o,
  input logic [DATA_W-1:0] msg_cause_o,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] enable_i,
  input logic [MODE_W-1:0] mode_i
);
  logic [DATA_W-1:0] src_prev;
  logic [DATA_W-1:0] rise_c;
  logic [DATA_W-1:0] clr_c;
  logic [DATA_W-1:0] keep_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_prev <= '0;
    else         src_prev <= src_i;
  end

  assign rise_c = src_i & ~src_prev & SRC_MASK;
  assign clr_c  = (reg_we_i && reg_addr_i == CLR_OFF) ? reg_wdata_i : '0;
  assign keep_c = status_i & ~clr_c;

  // R1 R3
  rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_c != '0) |=> ((status_i & $past(rise_c)) == $past(rise_c)));

  // R1
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(rise_c)) == '0));

  // R2
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & $past(keep_c)) == $past(keep_c)));

  // R4
  dead_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i | enable_i) & ~SRC_MASK) == '0);

  // R6
  wired_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_W'(1)) |-> (irq_o == ((status_i & enable_i) != '0)));

  // R6
  msg_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_W'(1)) |-> !irq_o);

  // R7
  msg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o);

  // R7
  msg_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_cause_o == (msg_valid_o ? (status_i & enable_i) : '0));
endmodule

bind irq_cause_unit irq_cause_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .MODE_W   (irq_cause_pkg::MODE_W),
  .SRC_MASK (SRC_MASK),
  .CLR_OFF  (ADDR_W'(irq_cause_pkg::OFF_CLR))
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .msg_valid_o (msg_valid_o),
  .msg_cause_o (msg_cause_o),
  .status_i    (status_q),
  .enable_i    (enable_q),
  .mode_i      (mode_q)
);

// File: tb/sim_irq_cause_unit.sv
module sim_irq_cause_unit;
  localparam logic [11:0] A_MODE = 12'h004;
  localparam logic [11:0] A_STAT = 12'h100;
  localparam logic [11:0] A_CLR  = 12'h108;
  localparam logic [11:0] A_ENA  = 12'h110;
  localparam logic [11:0] A_HOLE = 12'h0FC;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] src;
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic        irq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{4'd8,  32'h0000_0001, 1'b0, A_STAT, 32'h0,          32'h0000_0001, 1'b0}, // R8 latch while masked
    '{4'd5,  32'h0000_0001, 1'b1, A_ENA,  32'h0000_FFFF,  32'h0000_4E03, 1'b1}, // R5 R4
    '{4'd2,  32'h0000_0000, 1'b0, A_STAT, 32'h0,          32'h0000_0001, 1'b1}, // R2 hold
    '{4'd10, 32'h0000_0000, 1'b1, A_CLR,  32'h0000_0002,  32'h0000_0000, 1'b1}, // R10 clr reads 0
    '{4'd2,  32'h0000_0000, 1'b0, A_STAT, 32'h0,          32'h0000_0001, 1'b1}, // R2 other bit no effect
    '{4'd2,  32'h0000_0000, 1'b1, A_CLR,  32'h0000_0001,  32'h0000_0000, 1'b0}, // R2 clear
    '{4'd2,  32'h0000_0000, 1'b0, A_STAT, 32'h0,          32'h0000_0000, 1'b0}, // R2
    '{4'd4,  32'hFFFF_FFFF, 1'b0, A_STAT, 32'h0,          32'h0000_4E03, 1'b1}, // R4 R1
    '{4'd1,  32'hFFFF_FFFF, 1'b1, A_CLR,  32'hFFFF_FFFF,  32'h0000_0000, 1'b0}, // R1 level no reset
    '{4'd1,  32'hFFFF_FFFF, 1'b0, A_STAT, 32'h0,          32'h0000_0000, 1'b0}, // R1
    '{4'd1,  32'h0000_0000, 1'b0, A_STAT, 32'h0,          32'h0000_0000, 1'b0}, // R1 fall
    '{4'd3,  32'h0000_4000, 1'b1, A_CLR,  32'h0000_4000,  32'h0000_0000, 1'b1}, // R3 set wins
    '{4'd3,  32'h0000_4000, 1'b0, A_STAT, 32'h0,          32'h0000_4000, 1'b1}, // R3
    '{4'd8,  32'h0000_4000, 1'b1, A_ENA,  32'h0,          32'h0000_0000, 1'b0}, // R8 mask all
    '{4'd8,  32'h0000_4200, 1'b0, A_STAT, 32'h0,          32'h0000_4200, 1'b0}, // R8 latch
    '{4'd8,  32'h0000_0000, 1'b1, A_ENA,  32'h0000_0200,  32'h0000_0200, 1'b1}, // R8 re-enable
    '{4'd10, 32'h0000_0000, 1'b0, A_HOLE, 32'h0,          32'h0000_0000, 1'b1}, // R10 unmapped
    '{4'd5,  32'h0000_0000, 1'b1, A_CLR,  32'h0000_4200,  32'h0000_0000, 1'b0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [11:0] addr = A_STAT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        mvalid;
  logic [31:0] mcause;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  irq_cause_unit u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .msg_valid_o (mvalid),
    .msg_cause_o (mcause)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample 5 ns after the next rising edge
  task automatic step(input logic [31:0] s, input logic w, input logic [11:0] a, input logic [31:0] d);
    src = s; we = w; addr = a; wdata = d;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 irq in reset", 32'(irq), 32'h0);
    check("R9 msg in reset", 32'(mvalid), 32'h0);
    check("R9 status in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    step(32'h0, 1'b0, A_ENA, 32'h0);
    check("R9 enable reset", rdata, 32'h0);
    @(negedge clk);
    step(32'h0, 1'b0, A_MODE, 32'h0);
    check("R9 mode reset", rdata, 32'h1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VT[i].src, VT[i].we, VT[i].addr, VT[i].wdata);
      check($sformatf("R%0d vec %0d rdata", VT[i].req, i), rdata, VT[i].rd);
      check($sformatf("R%0d vec %0d irq", VT[i].req, i), 32'(irq), 32'(VT[i].irq));
      check($sformatf("R%0d vec %0d msg", VT[i].req, i), 32'(mvalid), 32'h0);
      @(negedge clk);
    end

    // message mode
    step(32'h0, 1'b1, A_MODE, 32'h0);
    check("R6 mode write", rdata, 32'h0);
    @(negedge clk);
    step(32'h0, 1'b1, A_ENA, 32'hFFFF_FFFF);
    check("R5 enable all", rdata, 32'h0000_4E03);
    @(negedge clk);
    step(32'h400, 1'b0, A_STAT, 32'h0);
    check("R7 pulse", 32'(mvalid), 32'h1);
    check("R7 payload", mcause, 32'h400);
    check("R6 line quiet in msg mode", 32'(irq), 32'h0);
    @(negedge clk);
    step(32'h400, 1'b0, A_STAT, 32'h0);
    check("R7 single cycle", 32'(mvalid), 32'h0);
    check("R7 payload idle", mcause, 32'h0);
    @(negedge clk);
    step(32'hC00, 1'b0, A_STAT, 32'h0);
    check("R7 status second", rdata, 32'h0000_0C00);
    check("R7 no pulse while nonzero", 32'(mvalid), 32'h0);
    @(negedge clk);
    step(32'h0, 1'b1, A_CLR, 32'hFFFF_FFFF);
    check("R7 clear all", 32'(mvalid), 32'h0);
    @(negedge clk);
    step(32'h2, 1'b0, A_STAT, 32'h0);
    check("R7 second pulse", 32'(mvalid), 32'h1);
    check("R7 second payload", mcause, 32'h2);
    @(negedge clk);
    step(32'h2, 1'b1, A_MODE, 32'hFFFF_FFF5);
    check("R6 mode field width", rdata, 32'h5);
    check("R6 non-one mode quiet", 32'(irq), 32'h0);
    @(negedge clk);
    step(32'h2, 1'b1, A_MODE, 32'h1);
    check("R6 wired resumes", 32'(irq), 32'h1);
    check("R7 no pulse in wired", 32'(mvalid), 32'h0);
    @(negedge clk);
    we = 1'b0;
    finish_run();
  end
endmodule